// File: doc/BRIEF.md
# Transmit Start and FIFO Head Retention Controller

This block sits beside a transmit FIFO and the MAC that drains it. For every frame it decides two things. The first is the cycle in which preamble transmission may begin: either the host has written enough of the frame to meet a programmable start point, or the frame's final byte is already in the FIFO. The second is the moment the FIFO may reclaim the space that holds the head of the frame.

In half duplex with retries enabled, the head is held until the first 64 bytes have gone out on the wire, or until the whole frame has gone out if the frame is shorter. This keeps a slot-time collision replayable from the FIFO without the host writing the data again. A collision inside that window produces a replay-pointer reset and rearms the start pulse, so the next attempt starts by itself. In full duplex, or with retries disabled, reclamation may begin once transmission has started.

All three outputs are registered. An output reflects the inputs sampled at the clock edge where it changes.

Top module: `tx_start_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `tx_start_o`, `ovwr_ok_o` and `replay_rst_o` are low.
- R2: With the start point selected by `start_sel_i` (0 = 4 bytes, 1 = 64, 2 = 128, 3 = 220), `tx_start_o` goes high after the edge that samples `wr_bytes_i` at or above that count for an armed frame. It stays low while the count is below the start point.
- R3: When `eof_written_i` is high for an armed frame, the start pulse fires whatever the start-point setting.
- R4: `tx_start_o` is high for exactly one cycle per attempt. No further pulse follows until a new frame begins or a replay rearms the attempt.
- R5: After the edge that samples `frame_begin_i`, `ovwr_ok_o` is low, and it stays low until the new frame has started.
- R6: In half duplex with retries enabled, `ovwr_ok_o` rises only after the edge that samples `sent_bytes_i` >= 64, or `eof_written_i` high with `sent_bytes_i` >= `wr_bytes_i`. Once set, it holds until the next frame begins.
- R7: In full duplex (`full_duplex_i` = 1) or with `retry_dis_i` = 1, `ovwr_ok_o` rises in the cycle after the start pulse.
- R8: A `collision_i` sampled in half duplex with retries enabled, after the start and while `ovwr_ok_o` is low, gives a one-cycle `replay_rst_o` after that edge. A new start pulse follows one cycle later if the start condition still holds.
- R9: A collision outside the retention window has no effect on any output. This covers a collision before the start, after `ovwr_ok_o` is set, in full duplex, or with retries disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_begin_i | input | 1 | One-cycle marker that a new frame starts being written |
| wr_bytes_i | input | CNT_W | Bytes of the current frame written to the FIFO |
| eof_written_i | input | 1 | Last byte of the current frame is in the FIFO |
| start_sel_i | input | 2 | Start-point code |
| full_duplex_i | input | 1 | Link runs full duplex |
| retry_dis_i | input | 1 | Collision retries disabled |
| sent_bytes_i | input | CNT_W | Bytes of the current attempt already on the wire |
| collision_i | input | 1 | Collision seen by the MAC |
| tx_start_o | output | 1 | One-cycle transmit start pulse |
| ovwr_ok_o | output | 1 | FIFO may reclaim the frame head |
| replay_rst_o | output | 1 | One-cycle reset of the FIFO replay pointer |

## Verification
A stuck arm flag shows at the ports as a missing start pulse, or as a repeated one, in the cycle after the threshold or end-of-frame condition. A retention flag that releases too early shows as `ovwr_ok_o` high while `sent_bytes_i` is still under 64 in half duplex. A flag that fails to clear shows as `ovwr_ok_o` still high one cycle after `frame_begin_i`. A window decision that accepts or drops the wrong collision is visible one cycle later on `replay_rst_o`, and one cycle after that on the re-fired `tx_start_o`.

// File: rtl/tx_start_pkg.sv
package tx_start_pkg;

  typedef enum logic [1:0] {
    SP_TINY   = 2'd0,
    SP_SLOT   = 2'd1,
    SP_DOUBLE = 2'd2,
    SP_DEEP   = 2'd3
  } start_pt_e;

  function automatic int unsigned pick_thresh(
    input start_pt_e   sel,
    input int unsigned t_tiny,
    input int unsigned t_slot,
    input int unsigned t_double,
    input int unsigned t_deep
  );
    case (sel)
      SP_TINY:   return t_tiny;
      SP_SLOT:   return t_slot;
      SP_DOUBLE: return t_double;
      default:   return t_deep;
    endcase
  endfunction

endpackage

// File: rtl/tx_start_thresh.sv
module tx_start_thresh
  import tx_start_pkg::*;
#(
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned T_TINY   = 4,
  parameter int unsigned T_SLOT   = 64,
  parameter int unsigned T_DOUBLE = 128,
  parameter int unsigned T_DEEP   = 220
) (
  input  logic [1:0]       start_sel_i,
  input  logic [CNT_W-1:0] wr_bytes_i,
  input  logic             eof_written_i,
  output logic             go_o
);
  logic [CNT_W-1:0] thresh;

  always_comb begin
    thresh = CNT_W'(pick_thresh(start_pt_e'(start_sel_i), T_TINY, T_SLOT, T_DOUBLE, T_DEEP));
    go_o   = eof_written_i || (wr_bytes_i >= thresh);
  end
endmodule

// File: rtl/tx_start_arm.sv
module tx_start_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_begin_i,
  input  logic go_i,
  input  logic replay_req_i,
  output logic started_o,
  output logic tx_start_o
);
  logic armed_q, started_q, start_q;
  logic fire;

  // new frame has priority: arm only, never fire on stale counts
  assign fire = armed_q && go_i && !frame_begin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      started_q <= 1'b0;
      start_q   <= 1'b0;
    end else begin
      start_q <= fire;
      if (frame_begin_i) begin
        armed_q   <= 1'b1;
        started_q <= 1'b0;
      end else if (replay_req_i) begin
        armed_q   <= 1'b1;
        started_q <= 1'b0;
      end else if (fire) begin
        armed_q   <= 1'b0;
        started_q <= 1'b1;
      end
    end
  end

  assign started_o  = started_q;
  assign tx_start_o = start_q;
endmodule

// File: rtl/tx_retain_ctrl.sv
module tx_retain_ctrl #(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned SLOT_BYTES = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_begin_i,
  input  logic             started_i,
  input  logic             full_duplex_i,
  input  logic             retry_dis_i,
  input  logic [CNT_W-1:0] sent_bytes_i,
  input  logic [CNT_W-1:0] wr_bytes_i,
  input  logic             eof_written_i,
  input  logic             collision_i,
  output logic             replay_req_o,
  output logic             replay_rst_o,
  output logic             ovwr_ok_o
);
  localparam logic [CNT_W-1:0] SlotCnt = CNT_W'(SLOT_BYTES);

  logic hold_head, head_out, release_ok;
  logic ovwr_q, replay_q;

  always_comb begin
    hold_head    = !full_duplex_i && !retry_dis_i;
    head_out     = (sent_bytes_i >= SlotCnt) ||
                   (eof_written_i && (sent_bytes_i >= wr_bytes_i));
    release_ok   = started_i && (!hold_head || head_out);
    replay_req_o = hold_head && started_i && !ovwr_q && collision_i && !frame_begin_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovwr_q   <= 1'b0;
      replay_q <= 1'b0;
    end else begin
      replay_q <= replay_req_o;
      if (frame_begin_i)      ovwr_q <= 1'b0;
      else if (replay_req_o)  ovwr_q <= 1'b0;
      else if (release_ok)    ovwr_q <= 1'b1;
    end
  end

  assign ovwr_ok_o    = ovwr_q;
  assign replay_rst_o = replay_q;
endmodule

// File: rtl/tx_start_ctrl.sv
module tx_start_ctrl #(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned SLOT_BYTES = 64,
  parameter int unsigned T_TINY     = 4,
  parameter int unsigned T_SLOT     = 64,
  parameter int unsigned T_DOUBLE   = 128,
  parameter int unsigned T_DEEP     = 220
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_begin_i,
  input  logic [CNT_W-1:0] wr_bytes_i,
  input  logic             eof_written_i,
  input  logic [1:0]       start_sel_i,
  input  logic             full_duplex_i,
  input  logic             retry_dis_i,
  input  logic [CNT_W-1:0] sent_bytes_i,
  input  logic             collision_i,
  output logic             tx_start_o,
  output logic             ovwr_ok_o,
  output logic             replay_rst_o
);
  logic go, started, replay_req;

  tx_start_thresh #(
    .CNT_W(CNT_W), .T_TINY(T_TINY), .T_SLOT(T_SLOT),
    .T_DOUBLE(T_DOUBLE), .T_DEEP(T_DEEP)
  ) u_thresh (
    .start_sel_i  (start_sel_i),
    .wr_bytes_i   (wr_bytes_i),
    .eof_written_i(eof_written_i),
    .go_o         (go)
  );

  tx_start_arm u_arm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_begin_i(frame_begin_i),
    .go_i         (go),
    .replay_req_i (replay_req),
    .started_o    (started),
    .tx_start_o   (tx_start_o)
  );

  tx_retain_ctrl #(.CNT_W(CNT_W), .SLOT_BYTES(SLOT_BYTES)) u_retain (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_begin_i(frame_begin_i),
    .started_i    (started),
    .full_duplex_i(full_duplex_i),
    .retry_dis_i  (retry_dis_i),
    .sent_bytes_i (sent_bytes_i),
    .wr_bytes_i   (wr_bytes_i),
    .eof_written_i(eof_written_i),
    .collision_i  (collision_i),
    .replay_req_o (replay_req),
    .replay_rst_o (replay_rst_o),
    .ovwr_ok_o    (ovwr_ok_o)
  );
endmodule

// File: rtl/tx_start_ctrl_chk.sv
module tx_start_ctrl_chk
  import tx_start_pkg::*;
#(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned SLOT_BYTES = 64,
  parameter int unsigned T_TINY     = 4,
  parameter int unsigned T_SLOT     = 64,
  parameter int unsigned T_DOUBLE   = 128,
  parameter int unsigned T_DEEP     = 220
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_begin_i,
  input logic [CNT_W-1:0] wr_bytes_i,
  input logic             eof_written_i,
  input logic [1:0]       start_sel_i,
  input logic             full_duplex_i,
  input logic             retry_dis_i,
  input logic [CNT_W-1:0] sent_bytes_i,
  input logic             collision_i,
  input logic             tx_start_o,
  input logic             ovwr_ok_o,
  input logic             replay_rst_o
);
  localparam logic [CNT_W-1:0] SlotCnt = CNT_W'(SLOT_BYTES);

  logic [CNT_W-1:0] cur_thresh;
  assign cur_thresh = CNT_W'(pick_thresh(start_pt_e'(start_sel_i), T_TINY, T_SLOT, T_DOUBLE, T_DEEP));

  p_start_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> $past(eof_written_i || (wr_bytes_i >= cur_thresh)));

  p_start_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o);

  p_clear_on_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_begin_i |=> !ovwr_ok_o);

  p_hold_head_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ovwr_ok_o) && $past(!full_duplex_i && !retry_dis_i)) |->
      $past((sent_bytes_i >= SlotCnt) || (eof_written_i && (sent_bytes_i >= wr_bytes_i))));

  p_fast_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_start_o && (full_duplex_i || retry_dis_i) && !frame_begin_i) |=> ovwr_ok_o);

  p_replay_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replay_rst_o |-> $past(collision_i && !full_duplex_i && !retry_dis_i && !ovwr_ok_o));

  p_replay_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replay_rst_o |=> !replay_rst_o);

  p_window_closed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (collision_i && ovwr_ok_o) |=> !replay_rst_o);
endmodule

bind tx_start_ctrl tx_start_ctrl_chk #(
  .CNT_W(CNT_W), .SLOT_BYTES(SLOT_BYTES), .T_TINY(T_TINY),
  .T_SLOT(T_SLOT), .T_DOUBLE(T_DOUBLE), .T_DEEP(T_DEEP)
) u_chk (.*);

// File: tb/tx_start_ctrl_bench.sv
`timescale 1ns/1ps
module tx_start_ctrl_bench;
  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             fb = 1'b0, eof = 1'b0, fd = 1'b0, rd = 1'b0, col = 1'b0;
  logic [CNT_W-1:0] wr = '0, sent = '0;
  logic [1:0]       sel = 2'd1;
  logic             tx_start, ovwr_ok, replay_rst;

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic  s;
    logic  o;
    logic  r;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  tx_start_ctrl u_tx_start_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .frame_begin_i(fb), .wr_bytes_i(wr),
    .eof_written_i(eof), .start_sel_i(sel), .full_duplex_i(fd),
    .retry_dis_i(rd), .sent_bytes_i(sent), .collision_i(col),
    .tx_start_o(tx_start), .ovwr_ok_o(ovwr_ok), .replay_rst_o(replay_rst)
  );

  task automatic check3(input logic s, o, r, input string tag);
    checks++;
    if (tx_start !== s || ovwr_ok !== o || replay_rst !== r) begin
      errors++;
      $display("FAIL %s: start/ovwr/replay got %b%b%b expected %b%b%b",
               tag, tx_start, ovwr_ok, replay_rst, s, o, r);
    end
  endtask

  // driver: apply one cycle of inputs and queue the outputs due after the next edge
  task automatic cyc(input logic f, input int w, input logic e, input int sl,
                     input logic d, input logic rdis, input int sn, input logic c,
                     input logic xs, xo, xr, input string tag);
    exp_t it;
    @(negedge clk);
    fb = f; wr = CNT_W'(w); eof = e; sel = 2'(sl);
    fd = d; rd = rdis; sent = CNT_W'(sn); col = c;
    it.s = xs; it.o = xo; it.r = xr; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      check3(it.s, it.o, it.r, it.tag);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check3(0, 0, 0, "R1 in reset");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 check3(0, 0, 0, "R1 after reset");

    // A: half duplex, start point 64
    cyc(1,  0, 0, 1, 0, 0,  0, 0, 0, 0, 0, "R5 frame A begin");
    cyc(0, 32, 0, 1, 0, 0,  0, 0, 0, 0, 0, "R2 below 64");
    cyc(0, 63, 0, 1, 0, 0,  0, 0, 0, 0, 0, "R2 one short");
    cyc(0, 64, 0, 1, 0, 0,  0, 0, 1, 0, 0, "R2 reach 64");
    cyc(0, 80, 0, 1, 0, 0,  0, 0, 0, 0, 0, "R4 single pulse");
    cyc(0, 90, 0, 1, 0, 0, 63, 0, 0, 0, 0, "R6 held at 63 sent");
    cyc(0, 90, 0, 1, 0, 0, 64, 0, 0, 1, 0, "R6 release at 64 sent");
    cyc(0,100, 0, 1, 0, 0, 70, 0, 0, 1, 0, "R4 no repeat start");

    // B: collision in window, start point 4
    cyc(1,  0, 0, 0, 0, 0,  0, 0, 0, 0, 0, "R5 clear on frame B");
    cyc(0,  3, 0, 0, 0, 0,  0, 0, 0, 0, 0, "R2 below 4");
    cyc(0, 10, 0, 0, 0, 0,  0, 0, 1, 0, 0, "R2 reach 4");
    cyc(0, 10, 0, 0, 0, 0, 20, 1, 0, 0, 1, "R8 replay pulse");
    cyc(0, 10, 0, 0, 0, 0,  0, 0, 1, 0, 0, "R8 restart");
    cyc(0, 90, 0, 0, 0, 0, 70, 0, 0, 1, 0, "R6 release after retry");
    cyc(0, 90, 0, 0, 0, 0, 80, 1, 0, 1, 0, "R9 late collision ignored");
    cyc(0, 90, 0, 0, 0, 0, 85, 0, 0, 1, 0, "R9 still quiet");

    // C: short frame, start point 220, end of frame written
    cyc(1,  0, 0, 3, 0, 0,  0, 0, 0, 0, 0, "R5 frame C begin");
    cyc(0, 40, 1, 3, 0, 0,  0, 0, 1, 0, 0, "R3 eof start");
    cyc(0, 40, 1, 3, 0, 0, 30, 0, 0, 0, 0, "R6 short frame held");
    cyc(0, 40, 1, 3, 0, 0, 40, 0, 0, 1, 0, "R6 short frame release");

    // D: full duplex, start point 128
    cyc(1,  0, 0, 2, 1, 0,  0, 0, 0, 0, 0, "R5 frame D begin");
    cyc(0,127, 0, 2, 1, 0,  0, 0, 0, 0, 0, "R2 below 128");
    cyc(0,128, 0, 2, 1, 0,  0, 0, 1, 0, 0, "R2 reach 128");
    cyc(0,140, 0, 2, 1, 0,  0, 0, 0, 1, 0, "R7 full duplex release");
    cyc(0,150, 0, 2, 1, 0,  5, 1, 0, 1, 0, "R9 full duplex collision");
    cyc(0,150, 0, 2, 1, 0,  6, 0, 0, 1, 0, "R9 full duplex quiet");

    // E: half duplex, retries disabled, start point 220
    cyc(1,  0, 0, 3, 0, 1,  0, 0, 0, 0, 0, "R5 frame E begin");
    cyc(0, 10, 0, 3, 0, 1,  0, 1, 0, 0, 0, "R9 collision before start");
    cyc(0,219, 0, 3, 0, 1,  0, 0, 0, 0, 0, "R2 below 220");
    cyc(0,220, 0, 3, 0, 1,  0, 0, 1, 0, 0, "R2 reach 220");
    cyc(0,230, 0, 3, 0, 1,  1, 1, 0, 1, 0, "R7 retry off release");

    // F: half duplex, collision before start is ignored
    cyc(1,  0, 0, 1, 0, 0,  0, 0, 0, 0, 0, "R5 frame F begin");
    cyc(0, 20, 0, 1, 0, 0,  0, 1, 0, 0, 0, "R9 pre-start collision");
    cyc(0, 20, 0, 1, 0, 0,  0, 0, 0, 0, 0, "R9 pre-start quiet");

    cyc(0, 20, 0, 1, 0, 0,  0, 0, 0, 0, 0, "R4 idle");
    @(posedge clk); #2;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule